// File: doc/BRIEF.md
# Converter Channel Sequencer with Sample Queue

This block sits between a 16-bit register bus and a 12-bit analog-to-digital converter. Software loads a list of 8-bit conversion descriptors, each naming an input channel, a gain step, a polarity and a single-ended or differential connection. It then selects a trigger mode. In software-trigger mode, a bus read of the start offset launches one conversion of the current descriptor. The list pointer then moves on, and after the last descriptor it wraps back to the first. After a fixed latency the converter result is placed in a sample queue. Software drains the queue by reading the data offset.

Results are stored in raw form, with the most significant bit of the 12-bit code inverted. Software recovers the true code by XOR with 0x800. A status word reports the queue level flags, the list-full flag and a sticky half-full event. A write to the status offset clears that event. Two enable bits in a second configuration register hold the list and the queue empty while they are low. The converter is a behavioural model: it samples the `ana_level` input when a conversion starts.

Top module: `adc_seq_front`

## Requirements
- R1: While a conversion runs, the descriptor it uses is shown on the converter pins: descriptor bits 3:0 on the channel pins, bits 5:4 on the gain pins, bit 6 on the unipolar pin and bit 7 on the differential pin.
- R2: Bits 1:0 written at offset 0x00 select the trigger mode: 0 off, 1 software, 2 scan, 3 external. A start read launches a conversion only in mode 1.
- R3: In mode 1, a read at offset 0x00 starts a conversion when the list holds at least one descriptor and the converter is idle. The converter reports busy from the next cycle, and the result enters the queue on the CONV_LAT-th clock edge after the start edge.
- R4: A read at offset 0x10 returns the oldest queued sample in bits 11:0, with zeros above, and removes it from the queue. The stored value equals the sampled level XOR 0x800. An empty queue reads as zero.
- R5: Conversions use the descriptors in the order they were written. After the last descriptor, the next conversion uses the first one again.
- R6: The status word at offset 0x04 shows: bit 4, queue full (16 samples); bit 3, queue at 8 or more samples; bit 2, queue empty; bit 1, list full (16 descriptors). After reset it reads 0x0004.
- R7: Offset 0x02 holds the queue enable in bit 10 and the list enable in bit 9. While an enable is 0, its store is emptied and held empty. Descriptor writes at offset 0x10 are ignored, and so are results arriving while the queue is disabled.
- R8: Status bit 8 becomes 1 in the cycle after the queue reaches 8 samples, and stays 1 until a write to offset 0x04. If a new event and a clear fall in the same cycle, the event wins.
- R9: A start read is ignored, and no sample is queued, when the list is empty or a conversion is already running.
- R10: A result that arrives while the queue is full is discarded, and the queued samples are unchanged.
- R11: When a result arrives in the same cycle as a queue read, both take effect: the oldest sample is returned and the new one is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_rd | input | 1 | Read strobe (side effects on the clock edge) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| ana_level | input | SAMPLE_W | Level the converter model samples at start |
| conv_busy_o | output | 1 | Conversion in progress |
| conv_chan_o | output | 4 | Channel of the active descriptor |
| conv_gain_o | output | 2 | Gain step of the active descriptor |
| conv_unipolar_o | output | 1 | Unipolar range selected |
| conv_diff_o | output | 1 | Differential input selected |

## Verification
The converter completion and a host read of the data offset can land on the same clock edge. That edge either moves a sample in and a sample out together, or it collides with a full queue. The bench times a data read to fall exactly CONV_LAT edges after a start read. It then judges the edge by the value returned, by the empty flag afterwards, and by the value left behind. A separate case fills the queue to 16 samples and completes one more conversion. Draining the queue then shows that the original 16 values came out in order and that the extra value was dropped.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;

   localparam int BUS_W = 16;

   // register byte offsets
   localparam int OFS_START = 'h00;
   localparam int OFS_CFG2  = 'h02;
   localparam int OFS_STAT  = 'h04;
   localparam int OFS_DATA  = 'h10;

   // status bit positions
   localparam int ST_PEND  = 8;
   localparam int ST_FULL  = 4;
   localparam int ST_HALF  = 3;
   localparam int ST_EMPTY = 2;
   localparam int ST_LFULL = 1;

   // second configuration register bit positions
   localparam int CF_QUEUE_EN = 10;
   localparam int CF_LIST_EN  = 9;

   typedef enum logic [1:0] {
      TRIG_OFF  = 2'd0,
      TRIG_SW   = 2'd1,
      TRIG_SCAN = 2'd2,
      TRIG_EXT  = 2'd3
   } trig_mode_e;

   typedef struct packed {
      logic       diff;
      logic       unipolar;
      logic [1:0] gain;
      logic [3:0] chan;
   } list_entry_t;

endpackage

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo #(
   parameter int W     = 12,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         half,
   output logic         empty
);
   localparam int  AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CW   = $clog2(DEPTH + 1);
   localparam bit  POW2 = (DEPTH == (1 << AW));

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("adc_sample_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;
   logic          push_ok, pop_ok;

   assign pop_ok  = pop && (cnt != '0);
   assign push_ok = push && ((cnt != CW'(DEPTH)) || pop_ok);

   generate
      if (POW2) begin : g_wrap_nat
         assign wp_nx = wp + AW'(1);
         assign rp_nx = rp + AW'(1);
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
         assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok && !clr) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push_ok) wp <= wp_nx;
         if (pop_ok)  rp <= rp_nx;
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   assign dout  = mem[rp];
   assign full  = (cnt == CW'(DEPTH));
   assign half  = (cnt >= CW'(DEPTH / 2));
   assign empty = (cnt == '0);

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

   // R10
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !clr) |=> full);

   // R7
   clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty);

endmodule

// File: rtl/adc_chan_list.sv
module adc_chan_list #(
   parameter int EW    = 8,
   parameter int DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr,
   input  logic [EW-1:0] wdata,
   input  logic          adv,
   output logic [EW-1:0] cur,
   output logic          empty,
   output logic          full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("adc_chan_list: DEPTH must be at least 2");
      end
   endgenerate

   logic [EW-1:0] mem [DEPTH];
   logic [CW-1:0] cnt;
   logic [AW-1:0] idx;
   logic          wr_ok, last;

   assign wr_ok = wr && !full && !clr;
   assign last  = (CW'(idx) == cnt - CW'(1));

   always_ff @(posedge clk) begin
      if (wr_ok) mem[cnt[AW-1:0]] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt <= '0;
         idx <= '0;
      end else begin
         if (wr_ok) cnt <= cnt + CW'(1);
         if (adv && !empty) idx <= last ? '0 : idx + AW'(1);
      end
   end

   assign cur   = mem[idx];
   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));

   // R5
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !empty |-> (CW'(idx) < cnt));

   // R5
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !empty && last && !clr) |=> (idx == '0));

endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
   parameter int W   = 12,
   parameter int LAT = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] level,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] raw
);
   localparam int CNTW = (LAT > 1) ? $clog2(LAT) : 1;
   localparam logic [W-1:0] MSB_FLIP = {1'b1, {(W-1){1'b0}}};

   generate
      if (LAT < 1) begin : g_bad_lat
         $error("adc_conv_stub: LAT must be at least 1");
      end
   endgenerate

   logic [CNTW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         raw  <= '0;
      end else if (start && !busy) begin
         busy <= 1'b1;
         cnt  <= CNTW'(LAT - 1);
         raw  <= level ^ MSB_FLIP;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - CNTW'(1);
      end
   end

   assign done = busy && (cnt == '0);

   // R3
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R3
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R9
   busy_raw_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(raw));

endmodule

// File: rtl/adc_seq_front.sv
module adc_seq_front
   import adc_fe_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int SAMPLE_W   = 12,
   parameter int FIFO_DEPTH = 16,
   parameter int LIST_DEPTH = 16,
   parameter int CONV_LAT   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_rd,
   input  logic                bus_wr,
   input  logic [15:0]         bus_wdata,
   output logic [15:0]         bus_rdata,
   input  logic [SAMPLE_W-1:0] ana_level,
   output logic                conv_busy_o,
   output logic [3:0]          conv_chan_o,
   output logic [1:0]          conv_gain_o,
   output logic                conv_unipolar_o,
   output logic                conv_diff_o
);
   localparam int EW = $bits(list_entry_t);

   generate
      if (SAMPLE_W > BUS_W) begin : g_bad_sw
         $error("adc_seq_front: SAMPLE_W wider than the bus");
      end
      if (ADDR_W < 5) begin : g_bad_aw
         $error("adc_seq_front: ADDR_W too narrow for the register offsets");
      end
   endgenerate

   // address decode
   logic at_start, at_cfg2, at_stat, at_data;
   assign at_start = (bus_addr == ADDR_W'(OFS_START));
   assign at_cfg2  = (bus_addr == ADDR_W'(OFS_CFG2));
   assign at_stat  = (bus_addr == ADDR_W'(OFS_STAT));
   assign at_data  = (bus_addr == ADDR_W'(OFS_DATA));

   trig_mode_e  mode_q;
   logic        queue_en, list_en;
   logic        pend_q, half_q;
   list_entry_t entry_q;

   logic             list_empty, list_full;
   logic [EW-1:0]    list_cur;
   logic             fifo_full, fifo_half, fifo_empty;
   logic [SAMPLE_W-1:0] fifo_dout, conv_raw;
   logic             conv_busy, conv_done;
   logic             start_rd, start_go, data_rd, pend_clr, half_rise;

   assign start_rd  = bus_rd && at_start;
   assign start_go  = start_rd && (mode_q == TRIG_SW) && !list_empty && !conv_busy;
   assign data_rd   = bus_rd && at_data && queue_en;
   assign pend_clr  = bus_wr && at_stat;
   assign half_rise = fifo_half && !half_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= TRIG_OFF;
         queue_en <= 1'b0;
         list_en  <= 1'b0;
         pend_q   <= 1'b0;
         half_q   <= 1'b0;
         entry_q  <= '0;
      end else begin
         if (bus_wr && at_start) mode_q <= trig_mode_e'(bus_wdata[1:0]);
         if (bus_wr && at_cfg2) begin
            queue_en <= bus_wdata[CF_QUEUE_EN];
            list_en  <= bus_wdata[CF_LIST_EN];
         end
         half_q <= fifo_half;
         pend_q <= half_rise | (pend_q & ~pend_clr);
         if (start_go) entry_q <= list_entry_t'(list_cur);
      end
   end

   adc_chan_list #(.EW(EW), .DEPTH(LIST_DEPTH)) list_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!list_en),
      .wr    (bus_wr && at_data),
      .wdata (bus_wdata[EW-1:0]),
      .adv   (start_go),
      .cur   (list_cur),
      .empty (list_empty),
      .full  (list_full)
   );

   adc_conv_stub #(.W(SAMPLE_W), .LAT(CONV_LAT)) conv_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start_go),
      .level (ana_level),
      .busy  (conv_busy),
      .done  (conv_done),
      .raw   (conv_raw)
   );

   adc_sample_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) fifo_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!queue_en),
      .push  (conv_done),
      .din   (conv_raw),
      .pop   (data_rd),
      .dout  (fifo_dout),
      .full  (fifo_full),
      .half  (fifo_half),
      .empty (fifo_empty)
   );

   logic [15:0] stat_w;
   always_comb begin
      stat_w           = '0;
      stat_w[ST_PEND]  = pend_q;
      stat_w[ST_FULL]  = fifo_full;
      stat_w[ST_HALF]  = fifo_half;
      stat_w[ST_EMPTY] = fifo_empty;
      stat_w[ST_LFULL] = list_full;
   end

   always_comb begin
      bus_rdata = '0;
      if (at_stat)                   bus_rdata = stat_w;
      else if (at_data && !fifo_empty) bus_rdata = BUS_W'(fifo_dout);
   end

   assign conv_busy_o     = conv_busy;
   assign conv_chan_o     = entry_q.chan;
   assign conv_gain_o     = entry_q.gain;
   assign conv_unipolar_o = entry_q.unipolar;
   assign conv_diff_o     = entry_q.diff;

   logic unused_wbits;
   assign unused_wbits = ^{bus_wdata[15:11], bus_wdata[8]};

   // R9
   empty_list_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_rd && list_empty && !conv_busy) |=> !conv_busy);

   // R2
   mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_rd && (mode_q != TRIG_SW) && !conv_busy) |=> !conv_busy);

   // R7
   list_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !list_en |=> list_empty);

   // R8
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fifo_half) |=> pend_q);

   // R8
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !pend_clr) |=> pend_q);

endmodule

// File: tb/adc_seq_front_tb_top.sv
`timescale 1ns/1ps
module adc_seq_front_tb_top;
   localparam int LAT = 4;
   localparam logic [15:0] EN_BOTH = 16'h0600;
   localparam logic [15:0] EN_QUEUE = 16'h0400;
   localparam logic [15:0] EN_LIST = 16'h0200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [11:0] ana_level = '0;
   logic        conv_busy_o, conv_unipolar_o, conv_diff_o;
   logic [3:0]  conv_chan_o;
   logic [1:0]  conv_gain_o;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   adc_seq_front dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ana_level(ana_level), .conv_busy_o(conv_busy_o),
      .conv_chan_o(conv_chan_o), .conv_gain_o(conv_gain_o),
      .conv_unipolar_o(conv_unipolar_o), .conv_diff_o(conv_diff_o)
   );

   function automatic logic [7:0] ent(int i);
      return 8'((i & 15) | (((i * 3) & 3) << 4) | ((i & 1) << 6) | (((i >> 1) & 1) << 7));
   endfunction

   function automatic logic [11:0] lvl(int i);
      return 12'((i * 273 + 5) & 'hFFF);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // all tasks start just after a falling edge and end just after one
   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [15:0] v);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic peek(input logic [5:0] a, output logic [15:0] v);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      logic [7:0]  e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R6 reset state
      peek(6'h04, v);
      chk(v == 16'h0004, "R6 reset status", v, 16'h0004);
      chk(conv_busy_o == 1'b0, "R3 idle after reset", conv_busy_o, 0);

      wr(6'h02, EN_BOTH);
      wr(6'h00, 16'h0001);

      // R9 start with empty list
      rd(6'h00, v);
      chk(conv_busy_o == 1'b0, "R9 start on empty list ignored", conv_busy_o, 0);

      // R7 descriptor write ignored while list disabled
      wr(6'h02, EN_QUEUE);
      wr(6'h10, 16'h0005);
      wr(6'h02, EN_BOTH);
      rd(6'h00, v);
      chk(conv_busy_o == 1'b0, "R7 list write while disabled ignored", conv_busy_o, 0);

      // load 16 descriptors, R6 list-full flag
      for (int i = 0; i < 16; i++) begin
         peek(6'h04, v);
         chk(v[1] == 1'b0, "R6 list not full", v[1], 0);
         wr(6'h10, {8'h00, ent(i)});
      end
      peek(6'h04, v);
      chk(v[1] == 1'b1, "R6 list full flag", v[1], 1);
      wr(6'h10, 16'h00FF); // ignored, list is full

      // 16 conversions: R1 fields, R3 latency, R6 flags, R8 pending
      for (int i = 0; i < 16; i++) begin
         ana_level = lvl(i);
         e = ent(i);
         rd(6'h00, v);
         chk(conv_busy_o == 1'b1, "R3 busy after start", conv_busy_o, 1);
         chk({conv_diff_o, conv_unipolar_o, conv_gain_o, conv_chan_o} == e,
             "R1 descriptor fields", {conv_diff_o, conv_unipolar_o, conv_gain_o, conv_chan_o}, e);
         repeat (LAT - 1) @(negedge clk);
         if (i == 0) begin
            peek(6'h04, v);
            chk(v[2] == 1'b1, "R3 not queued before latency", v[2], 1);
         end
         @(negedge clk);
         if (i == 0) begin
            peek(6'h04, v);
            chk(v[2] == 1'b0, "R3 queued at latency", v[2], 0);
         end
         @(negedge clk);
         peek(6'h04, v);
         chk(v[4] == (i + 1 == 16), "R6 full flag", v[4], (i + 1 == 16));
         chk(v[3] == (i + 1 >= 8), "R6 half flag", v[3], (i + 1 >= 8));
         chk(v[2] == 1'b0, "R6 empty flag", v[2], 0);
         chk(v[8] == (i + 1 >= 8), "R8 pending flag", v[8], (i + 1 >= 8));
      end

      // R8 clear by status write
      wr(6'h04, 16'h0000);
      peek(6'h04, v);
      chk(v[8] == 1'b0, "R8 pending cleared", v[8], 0);

      // R10 result into full queue, R5 wrap to first descriptor
      ana_level = 12'h3C3;
      rd(6'h00, v);
      chk(conv_chan_o == ent(0)[3:0], "R5 wrap to first descriptor", conv_chan_o, ent(0)[3:0]);
      repeat (LAT + 1) @(negedge clk);
      peek(6'h04, v);
      chk(v[4] == 1'b1, "R10 queue still full", v[4], 1);

      // R4 drain 15 in order
      for (int i = 0; i < 15; i++) begin
         rd(6'h10, v);
         chk(v == {4'h0, lvl(i) ^ 12'h800}, "R4 sample value", v, {4'h0, lvl(i) ^ 12'h800});
      end

      // R11 completion and read on the same edge
      ana_level = 12'h0A5;
      rd(6'h00, v);
      chk(conv_chan_o == ent(1)[3:0], "R5 next descriptor", conv_chan_o, ent(1)[3:0]);
      repeat (LAT - 1) @(negedge clk);
      rd(6'h10, v);
      chk(v == {4'h0, lvl(15) ^ 12'h800}, "R11 returned oldest", v, {4'h0, lvl(15) ^ 12'h800});
      peek(6'h04, v);
      chk(v[2] == 1'b0, "R11 new sample kept", v[2], 0);
      rd(6'h10, v);
      chk(v == 16'h08A5, "R11 kept sample value", v, 16'h08A5);
      peek(6'h04, v);
      chk(v[2] == 1'b1, "R11 queue empty after", v[2], 1);
      peek(6'h10, v);
      chk(v == 16'h0000, "R4 empty queue reads zero", v, 0);

      // R2 mode gating
      for (int m = 0; m < 4; m++) begin
         if (m == 1) continue;
         wr(6'h00, 16'(m));
         rd(6'h00, v);
         chk(conv_busy_o == 1'b0, "R2 no start outside software mode", conv_busy_o, 0);
      end
      wr(6'h00, 16'h0001);

      // R9 start while busy
      ana_level = 12'h123;
      rd(6'h00, v);
      rd(6'h00, v);
      repeat (LAT + 2) @(negedge clk);
      rd(6'h10, v);
      chk(v == 16'h0923, "R9 single sample value", v, 16'h0923);
      peek(6'h04, v);
      chk(v[2] == 1'b1, "R9 second start ignored", v[2], 1);

      // R7 queue clear
      rd(6'h00, v);
      repeat (LAT + 1) @(negedge clk);
      peek(6'h04, v);
      chk(v[2] == 1'b0, "R7 sample present", v[2], 0);
      wr(6'h02, EN_LIST);
      wr(6'h02, EN_BOTH);
      peek(6'h04, v);
      chk(v[2] == 1'b1, "R7 queue emptied by disable", v[2], 1);

      // R7 list clear
      wr(6'h02, EN_QUEUE);
      wr(6'h02, EN_BOTH);
      peek(6'h04, v);
      chk(v[1] == 1'b0, "R7 list emptied", v[1], 0);
      rd(6'h00, v);
      chk(conv_busy_o == 1'b0, "R7 no start after list clear", conv_busy_o, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule